// File: doc/BRIEF.md
# Region-Masked Clamp Pulse Generator

This block produces the per-line clamp pulse of an image-sensor timing generator. A pixel counter restarts at each falling edge of the horizontal sync. Two programmable pixel positions set where the pulse rises and where it falls inside the line. A line counter restarts at each falling edge of the vertical sync and splits the frame into five line regions. Region 0 always opens at the vertical-sync edge. Regions 1 to 4 open at four programmable line positions.

Each region has its own enable bit, and an override bit can let the pulse through in every region. When a region is masked and the next region is not, the mask is held for one extra line. As a result, the first line after a masked stretch also gets no pulse. A global count field of zero suppresses the pulse everywhere. All settings are copied into shadow registers at the vertical-sync falling edge, so a new setting takes effect from the next frame.

Top module: `clamp_region_gen`

## Requirements
- R1: While `rst` is high, `clp_o` is 0. After reset the shadow settings are zero, so `clp_o` stays 0 until the first falling edge of `vd_i` has loaded a nonzero count.
- R2: The pixel index is 0 in the cycle after `hd_i` is first sampled low following a high sample, and it rises by one each cycle after that, saturating at its maximum. `clp_o` is registered. It is high in the cycle after a pixel index p with `tog_on_i <= p < tog_off_i` (shadow values), when the line is not masked.
- R3: If the shadow `tog_off_i` is less than or equal to the shadow `tog_on_i`, `clp_o` stays 0 for the whole frame.
- R4: A shadow `clp_cnt_i` of 0 keeps `clp_o` at 0 in every region.
- R5: The line index becomes 0 on a falling edge of `vd_i` and rises by one on each falling edge of `hd_i`. The current region is the highest r in 1..4 whose start line satisfies start <= line index, or 0 if there is none. The start line of region r sits at bits [12*r-1 : 12*(r-1)] of `start_i`.
- R6: With `all_on_i` = 0, bit r of `en_i` set to 1 lets the pulse through in region r, and 0 masks it.
- R7: With `all_on_i` = 1, the pulse appears in every region whatever `en_i` holds.
- R8: If a line is masked (R6), the line that follows it is also masked, even when its own region is enabled. This holds across frame starts too.
- R9: All setting inputs are sampled only at a falling edge of `vd_i`. A change in the middle of a frame has no effect until the next falling edge.
- R10: When `vd_i` and `hd_i` fall in the same cycle, both the line index and the pixel index restart at 0. A `vd_i` fall in the middle of a line restarts the line index only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_i | input | 1 | Horizontal sync, idle high, falling edge starts a line |
| vd_i | input | 1 | Vertical sync, idle high, falling edge starts a frame |
| clp_cnt_i | input | 3 | Global clamp count; 0 disables the pulse |
| tog_on_i | input | 12 | Pixel position where the pulse rises |
| tog_off_i | input | 12 | Pixel position where the pulse falls |
| start_i | input | 48 | Start lines of regions 1..4, 12 bits each, region 1 lowest |
| en_i | input | 5 | Per-region enable, bit r for region r |
| all_on_i | input | 1 | Override: pulse in all regions |
| clp_o | output | 1 | Registered clamp pulse |

## Verification
Two things can land in one cycle: a frame restart on the vertical-sync edge and a line restart on the horizontal-sync edge. In that cycle the line index, the pixel index, the shadow load and the extended-mask update all move together. The bench provokes this by making both syncs fall together on some frames, and by dropping the vertical sync in the middle of a line on others. A cycle-by-cycle reference built from the requirements judges the output in both cases. Mid-frame setting changes and the first line after a masked region fall at the same boundaries, so they are judged in the same way.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    parameter int PIX_W   = 12;
    parameter int LINE_W  = 12;
    parameter int CNT_W   = 3;
    parameter int N_REG   = 5;

    localparam int N_START  = N_REG - 1;
    localparam int REG_W    = $clog2(N_REG);
    localparam int NUM_SYNC = 2;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [REG_W-1:0]  reg_idx_t;

    typedef enum int {
        SYNC_VD = 0,
        SYNC_HD = 1
    } sync_e;

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        pix_t                 tog_on;
        pix_t                 tog_off;
        line_t [N_START-1:0]  start;
        logic [N_REG-1:0]     en;
        logic                 all_on;
    } clamp_cfg_t;

    function automatic pix_t pix_inc(pix_t p);
        return (&p) ? p : p + 1'b1;
    endfunction

    function automatic line_t line_inc(line_t l);
        return (&l) ? l : l + 1'b1;
    endfunction

    function automatic reg_idx_t region_of(line_t ln, line_t [N_START-1:0] st);
        reg_idx_t r;
        r = '0;
        for (int i = 0; i < N_START; i++) begin
            if (ln >= st[i]) r = reg_idx_t'(i + 1);
        end
        return r;
    endfunction

    function automatic logic in_window(pix_t p, pix_t on, pix_t off);
        return (p >= on) && (p < off);
    endfunction

endpackage

// File: rtl/clp_edge_det.sv
module clp_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic fall_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b1;
        else     sig_q <= sig_i;
    end

    assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/clp_counters.sv
module clp_counters
    import clamp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hd_fall_i,
    input  logic  vd_fall_i,
    output pix_t  pix_o,
    output line_t line_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_o  <= '0;
            line_o <= '0;
        end else begin
            if (hd_fall_i) pix_o <= '0;
            else           pix_o <= pix_inc(pix_o);

            if (vd_fall_i)      line_o <= '0;
            else if (hd_fall_i) line_o <= line_inc(line_o);
        end
    end
endmodule

// File: rtl/clp_region_mask.sv
module clp_region_mask
    import clamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_t      line_i,
    input  logic       line_evt_i,
    input  clamp_cfg_t cfg_i,
    output logic       raw_o,
    output logic       eff_o
);
    reg_idx_t region;
    logic     prev_mask;

    always_comb begin
        region = region_of(line_i, cfg_i.start);
        raw_o  = !cfg_i.all_on && !cfg_i.en[region];
    end

    always_ff @(posedge clk) begin
        if (rst)             prev_mask <= 1'b0;
        else if (line_evt_i) prev_mask <= raw_o;
    end

    assign eff_o = raw_o | prev_mask;
endmodule

// File: rtl/clamp_region_gen.sv
module clamp_region_gen
    import clamp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hd_i,
    input  logic                      vd_i,
    input  logic [CNT_W-1:0]          clp_cnt_i,
    input  logic [PIX_W-1:0]          tog_on_i,
    input  logic [PIX_W-1:0]          tog_off_i,
    input  logic [N_START*LINE_W-1:0] start_i,
    input  logic [N_REG-1:0]          en_i,
    input  logic                      all_on_i,
    output logic                      clp_o
);
    logic [NUM_SYNC-1:0] sync_in;
    logic [NUM_SYNC-1:0] sync_fall;
    logic                hd_fall;
    logic                vd_fall;
    pix_t                pix_cnt;
    line_t               line_cnt;
    clamp_cfg_t          cfg_in;
    clamp_cfg_t          shd;
    logic                mask_raw;
    logic                mask_eff;

    assign sync_in[SYNC_VD] = vd_i;
    assign sync_in[SYNC_HD] = hd_i;

    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
        clp_edge_det u_edge (
            .clk    (clk),
            .rst    (rst),
            .sig_i  (sync_in[g]),
            .fall_o (sync_fall[g])
        );
    end

    assign hd_fall = sync_fall[SYNC_HD];
    assign vd_fall = sync_fall[SYNC_VD];

    clp_counters u_cnt (
        .clk       (clk),
        .rst       (rst),
        .hd_fall_i (hd_fall),
        .vd_fall_i (vd_fall),
        .pix_o     (pix_cnt),
        .line_o    (line_cnt)
    );

    always_comb begin
        cfg_in.cnt     = clp_cnt_i;
        cfg_in.tog_on  = tog_on_i;
        cfg_in.tog_off = tog_off_i;
        cfg_in.start   = start_i;
        cfg_in.en      = en_i;
        cfg_in.all_on  = all_on_i;
    end

    always_ff @(posedge clk) begin
        if (rst)          shd <= '0;
        else if (vd_fall) shd <= cfg_in;
    end

    clp_region_mask u_mask (
        .clk        (clk),
        .rst        (rst),
        .line_i     (line_cnt),
        .line_evt_i (hd_fall | vd_fall),
        .cfg_i      (shd),
        .raw_o      (mask_raw),
        .eff_o      (mask_eff)
    );

    always_ff @(posedge clk) begin
        if (rst) clp_o <= 1'b0;
        else     clp_o <= (shd.cnt != '0) && !mask_eff &&
                          in_window(pix_cnt, shd.tog_on, shd.tog_off);
    end
endmodule

// File: rtl/clp_checker.sv
module clp_checker
    import clamp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       hd_fall,
    input logic       vd_fall,
    input pix_t       pix,
    input line_t      line,
    input clamp_cfg_t shd,
    input logic       mask_raw,
    input logic       mask_eff,
    input logic       clp
);
    a_r1_reset_low: assert property (@(posedge clk) rst |=> !clp);

    a_r4_count_zero: assert property (@(posedge clk) disable iff (rst)
        (shd.cnt == '0) |=> !clp);

    a_r2_outside_window: assert property (@(posedge clk) disable iff (rst)
        !((pix >= shd.tog_on) && (pix < shd.tog_off)) |=> !clp);

    a_r2_pix_restart: assert property (@(posedge clk) disable iff (rst)
        hd_fall |=> (pix == '0));

    a_r5_line_restart: assert property (@(posedge clk) disable iff (rst)
        vd_fall |=> (line == '0));

    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        mask_eff |=> !clp);

    a_r7_override: assert property (@(posedge clk) disable iff (rst)
        shd.all_on |-> !mask_raw);

    a_r8_extend: assert property (@(posedge clk) disable iff (rst)
        ((hd_fall || vd_fall) && mask_raw) |=> mask_eff);
endmodule

bind clamp_region_gen clp_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .hd_fall  (hd_fall),
    .vd_fall  (vd_fall),
    .pix      (pix_cnt),
    .line     (line_cnt),
    .shd      (shd),
    .mask_raw (mask_raw),
    .mask_eff (mask_eff),
    .clp      (clp_o)
);

// File: tb/clamp_region_gen_tb_top.sv
`timescale 1ns/1ps
module clamp_region_gen_tb_top;
    import clamp_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic hd, vd;
    logic [CNT_W-1:0] cnt;
    pix_t ton, toff;
    line_t [N_START-1:0] st;
    logic [N_REG-1:0] en;
    logic all_on;
    logic clp;

    int checks = 0;
    int fails  = 0;
    bit running = 0;
    bit done = 0;
    string phase = "R1 reset";

    always #2.5 clk = ~clk;

    clamp_region_gen dut_i (
        .clk(clk), .rst(rst), .hd_i(hd), .vd_i(vd),
        .clp_cnt_i(cnt), .tog_on_i(ton), .tog_off_i(toff),
        .start_i(st), .en_i(en), .all_on_i(all_on), .clp_o(clp)
    );

    // Reference model built from the requirements
    logic m_hdq, m_vdq, m_prev, m_clp;
    pix_t m_pix;
    line_t m_line;
    clamp_cfg_t m_shd;
    logic b_hf, b_vf, b_raw, b_eff;

    function automatic logic ref_masked(line_t l, clamp_cfg_t c);
        int r = 0;
        for (int i = 1; i <= N_START; i++) if (l >= c.start[i-1]) r = i;
        if (c.all_on) return 1'b0;
        return !c.en[r];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hdq <= 1'b1; m_vdq <= 1'b1; m_prev <= 1'b0; m_clp <= 1'b0;
            m_pix <= '0; m_line <= '0; m_shd <= '0;
        end else begin
            b_hf  = m_hdq && !hd;
            b_vf  = m_vdq && !vd;
            b_raw = ref_masked(m_line, m_shd);
            b_eff = b_raw || m_prev;
            m_clp <= (m_shd.cnt != 0) && !b_eff &&
                     (m_pix >= m_shd.tog_on) && (m_pix < m_shd.tog_off);
            m_pix <= b_hf ? pix_t'(0) : ((&m_pix) ? m_pix : m_pix + 1'b1);
            if (b_vf) m_line <= '0;
            else if (b_hf) m_line <= (&m_line) ? m_line : m_line + 1'b1;
            if (b_vf || b_hf) m_prev <= b_raw;
            if (b_vf) begin
                m_shd.cnt <= cnt; m_shd.tog_on <= ton; m_shd.tog_off <= toff;
                m_shd.start <= st; m_shd.en <= en; m_shd.all_on <= all_on;
            end
            m_hdq <= hd;
            m_vdq <= vd;
        end
    end

    always @(negedge clk) begin
        if (running) begin
            checks++;
            if (clp !== m_clp) begin
                fails++;
                $display("FAIL %s: clp_o=%b expected %b at %0t", phase, clp, m_clp, $time);
            end
        end
    end

    task automatic run_line(int len, int vd_at);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            hd = (c < 2) ? 1'b0 : 1'b1;
            vd = (vd_at >= 0 && c >= vd_at && c < vd_at + 3) ? 1'b0 : 1'b1;
        end
    endtask

    task automatic run_frame(int nl, int len, int vd_at);
        for (int l = 0; l < nl; l++) run_line(len, (l == 0) ? vd_at : -1);
    endtask

    task automatic set_cfg(int c, int on, int off, int s1, int s2, int s3, int s4,
                           logic [N_REG-1:0] e, logic m);
        cnt = CNT_W'(c); ton = pix_t'(on); toff = pix_t'(off);
        st[0] = line_t'(s1); st[1] = line_t'(s2); st[2] = line_t'(s3); st[3] = line_t'(s4);
        en = e; all_on = m;
    endtask

    initial begin
        rst = 1'b1; hd = 1'b1; vd = 1'b1;
        set_cfg(0, 0, 0, 0, 0, 0, 0, '0, 1'b0);
        running = 1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        phase = "R1 pre-frame";
        set_cfg(1, 2, 6, 3, 4, 5, 7, 5'b10101, 1'b0);
        run_line(12, -1); run_line(12, -1);

        phase = "R2/R5/R6/R8/R10 regions, VD with HD";
        run_frame(10, 12, 0);
        run_frame(10, 12, 0);

        phase = "R5/R10 VD mid-line";
        run_frame(10, 12, 5);
        run_frame(10, 12, 0);

        phase = "R7 override";
        set_cfg(2, 1, 9, 2, 3, 6, 8, 5'b00000, 1'b1);
        run_frame(10, 12, 0);
        run_frame(10, 12, 0);

        phase = "R4 count zero";
        set_cfg(0, 1, 9, 2, 3, 6, 8, 5'b11111, 1'b1);
        run_frame(10, 12, 0);
        run_frame(10, 12, 0);

        phase = "R3 empty window";
        set_cfg(3, 7, 7, 2, 3, 6, 8, 5'b11111, 1'b1);
        run_frame(8, 12, 0);
        set_cfg(3, 9, 3, 2, 3, 6, 8, 5'b11111, 1'b1);
        run_frame(8, 12, 0);
        run_frame(8, 12, 0);

        phase = "R9 shadow";
        set_cfg(1, 1, 5, 2, 4, 6, 8, 5'b11111, 1'b0);
        run_frame(3, 12, 0);
        set_cfg(0, 0, 11, 1, 2, 3, 4, 5'b00000, 1'b0);
        run_frame(7, 12, -1);
        set_cfg(1, 0, 11, 1, 2, 3, 4, 5'b01010, 1'b0);
        run_frame(9, 12, 0);

        phase = "R2/R5/R6/R7/R8/R10 random";
        void'($urandom(32'd1234));
        for (int f = 0; f < 12; f++) begin
            int s1, s2, s3, s4;
            s1 = 1 + int'($urandom % 3);
            s2 = s1 + 1 + int'($urandom % 3);
            s3 = s2 + 1 + int'($urandom % 3);
            s4 = s3 + 1 + int'($urandom % 3);
            set_cfg(int'($urandom % 4), int'($urandom % 8), int'($urandom % 14),
                    s1, s2, s3, s4, N_REG'($urandom), ($urandom % 4) == 0);
            run_frame(14, 16, (($urandom % 2) == 0) ? 0 : 4);
        end
        run_frame(14, 16, 0);

        running = 0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule